// File: doc/BRIEF.md
# Two-Port-Read Register File with Mirrored Storage

This block holds the general-purpose registers of a small 16-bit processor. An instruction that combines two registers needs both operands in the same cycle, so the file offers two read ports, each with its own address and data output. Reads are combinational: the data follows the address within the cycle. A single write port stores one word on the rising clock edge when its enable is high.

The storage is held twice. Each read port has a private copy of all registers, and every write is broadcast to both copies on the same edge. From the ports the block behaves exactly like one array with two read decoders, but each copy only needs a single read port, which suits single-read RAM cells. A synchronous, active-high reset clears every register in both copies, and it wins over a write in the same cycle.

Top module: `mirror_regfile`

## Requirements
- R1: The two read ports take independent 3-bit addresses and each returns the addressed register's 16-bit value combinationally, in the same cycle as the address.
- R2: When `wr_en` is 1 at a rising clock edge, `wr_data` is stored in the register selected by `wr_addr`, and from the following cycle both read ports return it for that address.
- R3: When `wr_en` is 0 at a rising clock edge, no register changes value.
- R4: When `rst` is 1 at a rising clock edge, all eight registers become zero.
- R5: Reset takes priority: with `rst` and `wr_en` both 1 at an edge, the addressed register becomes zero, not `wr_data`.
- R6: A read of the register being written in the same cycle returns the value held before that edge.
- R7: For equal read addresses, the two ports always return identical data, including after any sequence of writes.
- R8: All eight addresses, 0 through 7, are usable and full 16-bit patterns (0x0000 to 0xFFFF) are stored without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_addr_a | input | 3 | Read address, port A |
| rd_data_a | output | 16 | Read data, port A |
| rd_addr_b | input | 3 | Read address, port B |
| rd_data_b | output | 16 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |

## Verification
A fixed table writes a distinct pattern to each of the eight registers and then reads every address from both ports, which separates address decoding faults (a pattern landing in the wrong register) from a port reading the wrong copy. A pseudo-random stream of writes, some with the enable low, is then compared against a bench model with both ports aimed at the same and at different addresses, exposing a write that reaches only one copy or one that ignores the enable. Directed cases cover reading a register in the cycle it is written, reset asserted together with a write, and all-ones and all-zeros data at the lowest and highest addresses.

// File: rtl/mirror_regfile_pkg.sv
package mirror_regfile_pkg;

    localparam int unsigned DATA_W   = 16;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NUM_REGS-1:0] sel_t;

    // Broadcast write request delivered identically to every copy
    typedef struct packed {
        logic  clear;
        sel_t  sel;
        word_t data;
    } wr_req_t;

    function automatic sel_t decode_addr(input addr_t a);
        sel_t s;
        s = '0;
        s[a] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/mirror_wr_ctrl.sv
module mirror_wr_ctrl
    import mirror_regfile_pkg::*;
(
    input  logic    rst,
    input  logic    wr_en,
    input  addr_t   wr_addr,
    input  word_t   wr_data,
    output wr_req_t req
);

    always_comb begin
        req.clear = rst;
        req.sel   = (wr_en && !rst) ? decode_addr(wr_addr) : '0;
        req.data  = wr_data;
    end

endmodule

// File: rtl/mirror_bank.sv
module mirror_bank
    import mirror_regfile_pkg::*;
(
    input  logic    clk,
    input  wr_req_t req,
    input  addr_t   rd_addr,
    output word_t   rd_data
);

    word_t store [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (req.clear) begin
                store[i] <= '0;
            end else if (req.sel[i]) begin
                store[i] <= req.data;
            end
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/mirror_regfile.sv
module mirror_regfile
    import mirror_regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   rd_addr_a,
    output logic [DATA_W-1:0]   rd_data_a,
    input  logic [ADDR_W-1:0]   rd_addr_b,
    output logic [DATA_W-1:0]   rd_data_b,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data
);

    localparam int unsigned NUM_PORTS = 2;

    wr_req_t req;
    addr_t   rd_addr [NUM_PORTS];
    word_t   rd_data [NUM_PORTS];

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    mirror_wr_ctrl u_wr_ctrl (
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    // One private copy of the storage per read port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_copy
        mirror_bank u_bank (
            .clk     (clk),
            .req     (req),
            .rd_addr (rd_addr[p]),
            .rd_data (rd_data[p])
        );
    end

    // Assertions
    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    assert_reset_clears_R4: assert property (@(posedge clk) disable iff (!past_valid)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0));

    assert_write_lands_a_R2: assert property (@(posedge clk) disable iff (rst || !past_valid)
        ($past(wr_en) && !$past(rst) && rd_addr_a == $past(wr_addr)) |-> rd_data_a == $past(wr_data));

    assert_write_lands_b_R2: assert property (@(posedge clk) disable iff (rst || !past_valid)
        ($past(wr_en) && !$past(rst) && rd_addr_b == $past(wr_addr)) |-> rd_data_b == $past(wr_data));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (!$past(wr_en) && !$past(rst) && $stable(rd_addr_a) && $stable(rd_addr_b))
        |-> ($stable(rd_data_a) && $stable(rd_data_b)));

    assert_copies_agree_R7: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/test_mirror_regfile.sv
module test_mirror_regfile;
    import mirror_regfile_pkg::*;

    logic  clk = 1'b0;
    logic  rst;
    addr_t rd_addr_a, rd_addr_b, wr_addr;
    word_t rd_data_a, rd_data_b, wr_data;
    logic  wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    word_t model [NUM_REGS];

    always #4 clk = ~clk;

    mirror_regfile i_mirror_regfile (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Table: {address, data} written in order
    localparam int unsigned NVEC = 8;
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd3, 16'h1234}, {3'd0, 16'hA5A5}, {3'd7, 16'h5A5A}, {3'd1, 16'h0F0F},
        {3'd6, 16'hF0F0}, {3'd2, 16'h8001}, {3'd5, 16'h7FFE}, {3'd4, 16'hC3C3}
    };

    task automatic check(input string req, input word_t act, input word_t exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input addr_t a, input word_t d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) model[a] = d;
    endtask

    task automatic read_both(input string req, input addr_t a, input addr_t b);
        rd_addr_a = a; rd_addr_b = b;
        #1;
        check(req, rd_data_a, model[a]);
        check(req, rd_data_b, model[b]);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1357_2468;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R4: reset state on every address
        for (int i = 0; i < NUM_REGS; i++) read_both("R4", addr_t'(i), addr_t'(NUM_REGS-1-i));

        // R2/R8: table writes, then full readback on both ports (R1 crossed addresses)
        for (int v = 0; v < NVEC; v++) do_write(1'b1, VEC[v][18:16], VEC[v][15:0]);
        for (int i = 0; i < NUM_REGS; i++) read_both("R2", addr_t'(i), addr_t'(i));
        for (int i = 0; i < NUM_REGS; i++) read_both("R1", addr_t'(i), addr_t'((i + 3) % NUM_REGS));

        // R3/R7: random writes, some disabled, compared with model
        for (int k = 0; k < 200; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            do_write(seed[3], addr_t'(seed[18:16]), word_t'(seed[31:16] ^ seed[15:0]));
            read_both("R7", addr_t'(seed[18:16]), addr_t'(seed[18:16]));
            read_both("R3", addr_t'(seed[22:20]), addr_t'(seed[26:24]));
        end

        // R3: disabled write to a known register leaves it unchanged
        do_write(1'b0, 3'd5, 16'hDEAD);
        read_both("R3", 3'd5, 3'd5);

        // R6: same-cycle read returns old value, new one after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'hBEEF;
        rd_addr_a = 3'd2; rd_addr_b = 3'd2;
        #1;
        check("R6", rd_data_a, model[2]);
        check("R6", rd_data_b, model[2]);
        @(negedge clk);
        wr_en = 1'b0; model[2] = 16'hBEEF;
        read_both("R6", 3'd2, 3'd2);

        // R8: extreme data at extreme addresses
        do_write(1'b1, 3'd0, 16'hFFFF);
        do_write(1'b1, 3'd7, 16'h0000);
        read_both("R8", 3'd0, 3'd7);
        do_write(1'b1, 3'd7, 16'hFFFF);
        read_both("R8", 3'd7, 3'd0);

        // R5: reset together with a write
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h9999;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        rd_addr_a = 3'd4; rd_addr_b = 3'd4;
        #1;
        check("R5", rd_data_a, 16'h0000);
        check("R5", rd_data_b, 16'h0000);
        for (int i = 0; i < NUM_REGS; i++) read_both("R4", addr_t'(i), addr_t'(i));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule